// File: doc/BRIEF.md
# Back-Propagation Update-Term Generator

This block is the digital side of on-chip training for one layer of neurons. When a pass starts, it records the error of every output neuron and the digitized dot-product of every neuron. Each error is the target minus the neuron output, held as 8-bit sign-magnitude. Next it walks a one-hot select register across the hidden neurons. For each hidden neuron it captures the back-propagated error that the shared converter presents at that moment, and stores it in a buffer.

Finally it emits one weight-update term per output neuron, one per cycle. Each term is the error times the activation derivative times a learning-rate factor, scaled and saturated. The derivative comes from a table indexed by the stored dot-product. The term leaves as a pair of values with opposite signs: one for the positive column of the differential synapse and one for the negative column.

Analog parts are represented by plain digital ports. These are the crossbar, the converters and the pulse shaper.

Top module: `bp_update_gen`

## Requirements
- R1: After reset, `busy`, `bpSel`, `updValid`, `done` and every `hidErr` slot read zero.
- R2: Inputs `tgtIn`, `outIn` and `bpErrIn` are sign-magnitude: the top bit of each 8-bit field is the sign (1 means negative), the low 7 bits are the magnitude, and code 0x80 means zero. The recorded error of neuron i is target minus output, saturated to ±127. Neuron i occupies bits [8i+7:8i].
- R3: The derivative of a dot-product code d is taken from a table. The code is DP_W=6 bits, two's complement, and neuron i occupies bits [6i+5:6i]. The derivative is 15-|d| when |d|<16 and 0 otherwise, including d=-32.
- R4: `updPos` is the signed two's-complement value (error × derivative × `lrIn`) shifted right arithmetically by SHIFT=4, which rounds toward minus infinity. It is saturated to ±127. `updNeg` is exactly its negation in the same cycle.
- R5: A `start` seen while idle sets `bpSel` to 1 on the next cycle. The set bit then moves one place toward the MSB every cycle for NUM_HID=4 cycles, then `bpSel` goes to zero. `bpSel` never has more than one bit set.
- R6: The value on `bpErrIn` during the cycle in which `bpSel[i]` is high is stored in `hidErr` bits [8i+7:8i].
- R7: After the capture phase, `updValid` is high for NUM_OUT=4 consecutive cycles, with `updIdx` counting 0,1,2,3. `done` is high only together with index 3, and the block is idle on that cycle.
- R8: `tgtIn`, `outIn`, `dpIn` and `lrIn` are sampled on the edge that accepts `start`. Changing them later in the pass has no effect on that pass's outputs.
- R9: `start` is ignored while `busy` is high. A `start` present in the cycle that `done` is high begins a new pass at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a training pass when idle |
| lrIn | input | LR_W (4) | Unsigned learning-rate factor |
| tgtIn | input | NUM_OUT*ERR_W (32) | Target values, sign-magnitude, per output neuron |
| outIn | input | NUM_OUT*ERR_W (32) | Neuron outputs, sign-magnitude, per output neuron |
| dpIn | input | NUM_OUT*DP_W (24) | Digitized dot-products, two's complement, per neuron |
| bpErrIn | input | ERR_W (8) | Back-propagated error from the shared converter, sign-magnitude |
| bpSel | output | NUM_HID (4) | One-hot capture-path enable |
| busy | output | 1 | Pass in progress |
| updValid | output | 1 | Update term pair valid |
| updIdx | output | IDX_W (2) | Output neuron of the current term |
| updPos | output | UPD_W (8) | Signed term for the positive column |
| updNeg | output | UPD_W (8) | Signed term for the negative column |
| done | output | 1 | Last term of the pass |
| hidErr | output | NUM_HID*ERR_W (32) | Captured hidden-neuron errors |

## Verification
Two events can share one cycle: the last update term, which carries `done`, and the acceptance of a new `start`. The bench holds `start` high through a complete pass. Every request made while the block is busy must be dropped, so exactly four update terms appear before `done`. On the cycle after `done`, `bpSel` must already read 1, showing that the request present alongside `done` was taken. The bench also changes every sampled input in the middle of each pass. The terms must still match values computed from the inputs recorded at the start.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BACK = 2'd1,
    ST_EMIT = 2'd2
  } bpuState_t;

  typedef struct packed {
    logic record;   // latch errors, dot-products, rate
    logic capture;  // store bpErrIn into selected slot
    logic emit;     // produce one update term
    logic last;     // final term of the pass
  } bpuStrobe_t;

endpackage

// File: rtl/bpu_deriv_lut.sv
module bpu_deriv_lut #(
  parameter int DP_W = 6
) (
  input  logic [DP_W-1:0]   dpCode,
  output logic [DP_W-3:0]   deriv
);
  localparam int DER_W = DP_W - 2;
  localparam int TBL_N = 1 << DP_W;
  localparam int HALF  = 1 << (DP_W - 1);
  localparam int THR   = 1 << DER_W;

  function automatic logic [DER_W-1:0] derivOf(input int code);
    int sv;
    int mag;
    sv  = (code >= HALF) ? code - TBL_N : code;
    mag = (sv < 0) ? -sv : sv;
    return (mag < THR) ? DER_W'(THR - 1 - mag) : '0;
  endfunction

  logic [DER_W-1:0] lutMem [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
    assign lutMem[k] = derivOf(k);
  end

  assign deriv = lutMem[dpCode];

endmodule

// File: rtl/bpu_ctrl.sv
module bpu_ctrl
  import bpu_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_HID = 4,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output bpuStrobe_t         strb,
  output logic [NUM_HID-1:0] bpSel,
  output logic [IDX_W-1:0]   emitIdx,
  output logic               busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OUT - 1);

  bpuState_t state;

  always_comb begin
    strb.record  = (state == ST_IDLE) && start;
    strb.capture = (state == ST_BACK);
    strb.emit    = (state == ST_EMIT);
    strb.last    = (state == ST_EMIT) && (emitIdx == LAST_IDX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bpSel   <= '0;
      emitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_BACK;
            bpSel <= NUM_HID'(1);
          end
        end
        ST_BACK: begin
          bpSel <= bpSel << 1;
          if (bpSel[NUM_HID-1]) begin
            state   <= ST_EMIT;
            emitIdx <= '0;
          end
        end
        ST_EMIT: begin
          emitIdx <= emitIdx + IDX_W'(1);
          if (emitIdx == LAST_IDX) begin
            state   <= ST_IDLE;
            emitIdx <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bpu_datapath.sv
module bpu_datapath
  import bpu_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_HID = 4,
  parameter int ERR_W   = 8,
  parameter int DP_W    = 6,
  parameter int LR_W    = 4,
  parameter int SHIFT   = 4,
  parameter int UPD_W   = 8,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bpuStrobe_t                 strb,
  input  logic [NUM_HID-1:0]         bpSel,
  input  logic [IDX_W-1:0]           emitIdx,
  input  logic [NUM_OUT*ERR_W-1:0]   tgtIn,
  input  logic [NUM_OUT*ERR_W-1:0]   outIn,
  input  logic [NUM_OUT*DP_W-1:0]    dpIn,
  input  logic [LR_W-1:0]            lrIn,
  input  logic [ERR_W-1:0]           bpErrIn,
  output logic                       updValid,
  output logic [IDX_W-1:0]           updIdx,
  output logic [UPD_W-1:0]           updPos,
  output logic [UPD_W-1:0]           updNeg,
  output logic                       done,
  output logic [NUM_HID*ERR_W-1:0]   hidErr
);
  localparam int DER_W  = DP_W - 2;
  localparam int DIFF_W = ERR_W + 2;
  localparam int PROD_W = (ERR_W + 1) + (DER_W + 1) + (LR_W + 1);
  localparam int UMAX_I = (1 << (UPD_W - 1)) - 1;
  localparam logic signed [DIFF_W-1:0] EMAX = DIFF_W'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] UMAX = PROD_W'(UMAX_I);
  localparam logic signed [PROD_W-1:0] UMIN = -PROD_W'(UMAX_I);

  // sign-magnitude to two's complement
  function automatic logic signed [ERR_W:0] smToTc(input logic [ERR_W-1:0] v);
    logic signed [ERR_W:0] m;
    m = $signed({2'b00, v[ERR_W-2:0]});
    return v[ERR_W-1] ? -m : m;
  endfunction

  // saturating two's complement difference back to sign-magnitude
  function automatic logic [ERR_W-1:0] diffToSm(input logic signed [DIFF_W-1:0] d);
    logic signed [DIFF_W-1:0] a;
    a = (d < 0) ? -d : d;
    if (a > EMAX) a = EMAX;
    return {(d < 0), a[ERR_W-2:0]};
  endfunction

  logic [ERR_W-1:0] errReg [NUM_OUT];
  logic [DP_W-1:0]  dpReg  [NUM_OUT];
  logic [ERR_W-1:0] errNext[NUM_OUT];
  logic [LR_W-1:0]  lrReg;

  // ---- record stage: per-neuron error formation ----
  for (genvar n = 0; n < NUM_OUT; n++) begin : g_err
    logic signed [DIFF_W-1:0] diff;
    assign diff       = DIFF_W'(smToTc(tgtIn[n*ERR_W +: ERR_W]))
                      - DIFF_W'(smToTc(outIn[n*ERR_W +: ERR_W]));
    assign errNext[n] = diffToSm(diff);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errReg[n] <= '0;
        dpReg[n]  <= '0;
      end else if (strb.record) begin
        errReg[n] <= errNext[n];
        dpReg[n]  <= dpIn[n*DP_W +: DP_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lrReg <= '0;
    else if (strb.record) lrReg <= lrIn;
  end

  // ---- capture stage: one-hot selected buffer slot ----
  for (genvar h = 0; h < NUM_HID; h++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        hidErr[h*ERR_W +: ERR_W] <= '0;
      else if (strb.capture && bpSel[h]) hidErr[h*ERR_W +: ERR_W] <= bpErrIn;
    end
  end

  // ---- emit stage: derivative, multiply, scale, saturate ----
  logic [DER_W-1:0]          deriv;
  logic signed [ERR_W:0]     errS;
  logic signed [PROD_W-1:0]  eExt, dExt, lExt, prod, scaled;
  logic signed [UPD_W-1:0]   satVal;

  bpu_deriv_lut #(.DP_W(DP_W)) u_lut (
    .dpCode (dpReg[emitIdx]),
    .deriv  (deriv)
  );

  always_comb begin
    errS   = smToTc(errReg[emitIdx]);
    eExt   = PROD_W'(errS);
    dExt   = PROD_W'({1'b0, deriv});
    lExt   = PROD_W'({1'b0, lrReg});
    prod   = eExt * dExt * lExt;
    scaled = prod >>> SHIFT;
    if (scaled > UMAX)      satVal = UPD_W'(UMAX);
    else if (scaled < UMIN) satVal = UPD_W'(UMIN);
    else                    satVal = UPD_W'(scaled);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updValid <= 1'b0;
      done     <= 1'b0;
      updIdx   <= '0;
      updPos   <= '0;
      updNeg   <= '0;
    end else begin
      updValid <= strb.emit;
      done     <= strb.last;
      if (strb.emit) begin
        updIdx <= emitIdx;
        updPos <= satVal;
        updNeg <= -satVal;
      end
    end
  end

endmodule

// File: rtl/bp_update_gen.sv
module bp_update_gen
  import bpu_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_HID = 4,
  parameter int ERR_W   = 8,
  parameter int DP_W    = 6,
  parameter int LR_W    = 4,
  parameter int SHIFT   = 4,
  parameter int UPD_W   = 8,
  parameter int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [LR_W-1:0]          lrIn,
  input  logic [NUM_OUT*ERR_W-1:0] tgtIn,
  input  logic [NUM_OUT*ERR_W-1:0] outIn,
  input  logic [NUM_OUT*DP_W-1:0]  dpIn,
  input  logic [ERR_W-1:0]         bpErrIn,
  output logic [NUM_HID-1:0]       bpSel,
  output logic                     busy,
  output logic                     updValid,
  output logic [IDX_W-1:0]         updIdx,
  output logic [UPD_W-1:0]         updPos,
  output logic [UPD_W-1:0]         updNeg,
  output logic                     done,
  output logic [NUM_HID*ERR_W-1:0] hidErr
);
  bpuStrobe_t       strb;
  logic [IDX_W-1:0] emitIdx;

  bpu_ctrl #(.NUM_OUT(NUM_OUT), .NUM_HID(NUM_HID), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .bpSel   (bpSel),
    .emitIdx (emitIdx),
    .busy    (busy)
  );

  bpu_datapath #(
    .NUM_OUT(NUM_OUT), .NUM_HID(NUM_HID), .ERR_W(ERR_W), .DP_W(DP_W),
    .LR_W(LR_W), .SHIFT(SHIFT), .UPD_W(UPD_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bpSel    (bpSel),
    .emitIdx  (emitIdx),
    .tgtIn    (tgtIn),
    .outIn    (outIn),
    .dpIn     (dpIn),
    .lrIn     (lrIn),
    .bpErrIn  (bpErrIn),
    .updValid (updValid),
    .updIdx   (updIdx),
    .updPos   (updPos),
    .updNeg   (updNeg),
    .done     (done),
    .hidErr   (hidErr)
  );

endmodule

// File: rtl/bp_update_gen_chk.sv
module bp_update_gen_chk #(
  parameter int NUM_OUT = 4,
  parameter int NUM_HID = 4,
  parameter int UPD_W   = 8,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [NUM_HID-1:0] bpSel,
  input logic               busy,
  input logic               updValid,
  input logic [IDX_W-1:0]   updIdx,
  input logic [UPD_W-1:0]   updPos,
  input logic [UPD_W-1:0]   updNeg,
  input logic               done
);
  localparam logic [UPD_W-1:0] MOST_NEG = {1'b1, {(UPD_W-1){1'b0}}};

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bpSel));

  // R5
  sel_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (bpSel == NUM_HID'(1)));

  // R4
  upd_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> ($signed(updNeg) == -$signed(updPos)));

  // R4
  upd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> (updPos != MOST_NEG));

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (updValid && updIdx == IDX_W'(NUM_OUT - 1)));

  // R7
  emit_quiet_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> (bpSel == '0));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind bp_update_gen bp_update_gen_chk #(
  .NUM_OUT(NUM_OUT), .NUM_HID(NUM_HID), .UPD_W(UPD_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .bpSel(bpSel), .busy(busy),
  .updValid(updValid), .updIdx(updIdx), .updPos(updPos), .updNeg(updNeg),
  .done(done)
);

// File: tb/bp_update_gen_tb.sv
module bp_update_gen_tb;
  localparam int NO = 4;
  localparam int NH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0]  lrIn = '0;
  logic [31:0] tgtIn = '0, outIn = '0;
  logic [23:0] dpIn = '0;
  logic [7:0]  bpErrIn = '0;
  logic [3:0]  bpSel;
  logic        busy, updValid, done;
  logic [1:0]  updIdx;
  logic [7:0]  updPos, updNeg;
  logic [31:0] hidErr;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bp_update_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .lrIn(lrIn), .tgtIn(tgtIn),
    .outIn(outIn), .dpIn(dpIn), .bpErrIn(bpErrIn), .bpSel(bpSel),
    .busy(busy), .updValid(updValid), .updIdx(updIdx), .updPos(updPos),
    .updNeg(updNeg), .done(done), .hidErr(hidErr)
  );

  // stimulus / expected table: sign-magnitude target & output, 6-bit dp, expected term
  localparam logic [7:0] TGT_T [12] = '{8'h28, 8'h05, 8'h94, 8'h80,
                                        8'h7F, 8'hFF, 8'h03, 8'h01,
                                        8'h32, 8'h00, 8'h40, 8'h0C};
  localparam logic [7:0] OUT_T [12] = '{8'h1E, 8'h14, 8'h0A, 8'h87,
                                        8'hFF, 8'h7F, 8'h03, 8'h02,
                                        8'hB2, 8'h01, 8'h00, 8'h0B};
  localparam logic [5:0] DP_T  [12] = '{6'h00, 6'h3C, 6'h14, 6'h05,
                                        6'h01, 6'h3F, 6'h00, 6'h32,
                                        6'h02, 6'h20, 6'h38, 6'h00};
  localparam int         EXP_T [12] = '{75, -83, 0, 35,
                                        127, -127, 0, -1,
                                        127, 0, 84, 2};
  localparam logic [3:0] LR_T  [3]  = '{4'd8, 4'd15, 4'd3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hv(input int p, input int i);
    return 8'(((i % 2) << 7) | (p * 16 + i + 3));
  endfunction

  task automatic loadPass(input int p);
    for (int i = 0; i < NO; i++) begin
      tgtIn[i*8 +: 8] = TGT_T[p*NO + i];
      outIn[i*8 +: 8] = OUT_T[p*NO + i];
      dpIn[i*6 +: 6]  = DP_T[p*NO + i];
    end
    lrIn = LR_T[p];
  endtask

  task automatic runPass(input int p);
    @(negedge clk);
    loadPass(p);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R8: disturb every sampled input after acceptance
    tgtIn = '1; outIn = '0; dpIn = '0; lrIn = 4'd1;
    check(busy == 1'b1, "R5 busy", int'(busy), 1);
    for (int i = 0; i < NH; i++) begin
      check(bpSel == 4'(1 << i), "R5 bpSel", int'(bpSel), 1 << i);
      bpErrIn = hv(p, i);
      @(posedge clk);
      @(negedge clk);
    end
    check(bpSel == 4'd0 && !updValid, "R7 gap", int'(bpSel), 0);
    for (int j = 0; j < NO; j++) begin
      @(posedge clk);
      @(negedge clk);
      check(updValid && updIdx == 2'(j), "R7 index", int'(updIdx), j);
      check($signed(updPos) == EXP_T[p*NO + j], "R2 R3 R4 R8 updPos",
            int'($signed(updPos)), EXP_T[p*NO + j]);
      check($signed(updNeg) == -EXP_T[p*NO + j], "R4 updNeg",
            int'($signed(updNeg)), -EXP_T[p*NO + j]);
      check(done == (j == NO - 1), "R7 done", int'(done), int'(j == NO - 1));
    end
    for (int i = 0; i < NH; i++)
      check(hidErr[i*8 +: 8] == hv(p, i), "R6 hidErr",
            int'(hidErr[i*8 +: 8]), int'(hv(p, i)));
    @(posedge clk);
    @(negedge clk);
    check(!busy && !updValid && !done, "R7 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && bpSel == 0 && !updValid && !done && hidErr == 0,
          "R1 reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 3; p++) runPass(p);

    // R9: start held high through a full pass
    @(negedge clk);
    loadPass(0);
    start = 1'b1;
    begin
      int nUpd = 0;
      int guard = 0;
      @(posedge clk);
      @(negedge clk);
      while (!done && guard < 50) begin
        if (updValid) nUpd++;
        @(posedge clk);
        @(negedge clk);
        guard++;
      end
      if (updValid) nUpd++;
      check(nUpd == NO, "R9 ignored while busy", nUpd, NO);
      check(done && !busy, "R9 done cycle idle", int'(busy), 0);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(busy && bpSel == 4'd1, "R9 start with done", int'(bpSel), 1);
    end
    // let the second pass run, then verify its first term
    begin
      int guard = 0;
      while (!updValid && guard < 50) begin
        @(posedge clk);
        @(negedge clk);
        guard++;
      end
      check($signed(updPos) == EXP_T[0], "R9 R4 second pass",
            int'($signed(updPos)), EXP_T[0]);
      while (busy && guard < 100) begin
        @(posedge clk);
        @(negedge clk);
        guard++;
      end
    end

    // R1: reset in the middle of a pass
    @(negedge clk);
    loadPass(1);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    bpErrIn = 8'h55;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!busy && bpSel == 0 && !updValid && hidErr == 0, "R1 mid-pass reset",
          int'(bpSel), 0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule